// File: doc/BRIEF.md
# Gate-Driver Fault Supervisor

This block sits between the fault detectors of a three-phase gate driver and its six gate outputs. It receives fault indications for overtemperature, gate-supply undervoltage, high-side short, low-side short and overcurrent. It also receives a main-supply-low level, a sleep control and a temperature-OK level. From these it derives a single output enable, an active-low fault pin and a start-ready flag. The output enable forces all gates low.

Each fault class is given a policy at elaboration time through a mask parameter. A class can latch off, which needs a sleep cycle or a supply dip to clear. It can instead retry on its own. A retrying overtemperature fault recovers once the temperature-OK level comes back. Overcurrent and low-side shorts recover after a counted off time, which is captured from a 16-bit input at the moment of the fault. A short waits three times as long as an overcurrent for the same setting. A retrying gate-supply fault recovers through a bootstrap-charge phase before the gates drive again.

A main-supply-low level wipes all fault state. After it clears, and after reset, the gates stay disabled for a start-up hold-off of about 1 ms, counted in ticks of a 1 MHz prescaler.

Top module: `fault_supervisor`

## Requirements
- R1: A fault indication sampled at a clock edge drives `gate_en` low immediately after that edge. For overcurrent and low-side short this requires a non-zero off-time setting.
- R2: A fault of a latching class holds `gate_en` low and `fault_n` low. Only `sleep_n` low followed by high, or `supply_low`, clears it. With the default mask, only the high-side short latches (mask bit 2).
- R3: While `supply_low` is high, all fault state is cleared. From the following edge on, `fault_n` reads 1 and `start_ready` reads 0.
- R4: After reset and after `supply_low` falls, `start_ready` and `gate_en` stay low for `STARTUP_TICKS` ticks. Each tick is `TICK_DIV` clocks. They then rise.
- R5: A retrying overtemperature fault keeps the gates off while `temp_ok` is low. The gates enable in the cycle after `temp_ok` is sampled high.
- R6: A low-side short retries after three times `off_time` ticks. A high-side short latches.
- R7: An overcurrent drives `fault_n` low and `gate_en` low for `off_time` ticks. Both then return high on their own.
- R8: The off time is captured when the fault occurs. Later changes of `off_time` do not alter a running off period.
- R9: When a retrying gate-supply fault clears, `bst_req` goes high for `BST_TICKS` ticks. During that time `gate_en` stays low and `fault_n` is high. Normal driving resumes afterwards.
- R10: When a latching and a retrying fault arrive in the same cycle, the latch wins. The outputs stay off past the retry time.
- R11: While `sleep_n` is low, `gate_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_low | input | 1 | Main supply below threshold (level) |
| sleep_n | input | 1 | Active-low sleep control |
| temp_ok | input | 1 | Sampled die temperature acceptable (level) |
| ot_flt | input | 1 | Overtemperature strobe |
| gv_low | input | 1 | Gate-drive supply below threshold (level) |
| hs_short | input | 1 | High-side short strobe |
| ls_short | input | 1 | Low-side short strobe |
| oc_flt | input | 1 | Overcurrent strobe |
| off_time | input | OFF_W | Retry off time in ticks, captured at fault |
| gate_en | output | 1 | Gate enable; 0 forces all six gates low |
| fault_n | output | 1 | Active-low fault indication |
| start_ready | output | 1 | Start-up hold-off complete |
| bst_req | output | 1 | Bootstrap charge sequence request |

## Verification
The bench checks the off-time boundaries on both sides. A design that counts the short off time like an overcurrent would re-enable near one third of the expected time. A design that reloads the off time live would stretch the period after `off_time` is raised mid-fault. Simultaneous latch and retry faults, and a latch cleared by a supply dip rather than by sleep, expose a design that lets a retry timer release a latched fault, or that leaves a latch set across a supply reset. The gate-supply recovery is sampled during the charge phase, which catches a design that enables the gates before the bootstrap request ends.

// File: rtl/fs_pkg.sv
// Shared constants for the fault supervisor: fault class indices and widths.
// Assumes five fault classes in a fixed vector order used by the policy mask.
package fs_pkg;
    localparam int NUM_CLASSES = 5;
    localparam int C_OT = 0;   // overtemperature
    localparam int C_GV = 1;   // gate-drive supply low
    localparam int C_HS = 2;   // high-side short
    localparam int C_LS = 3;   // low-side short
    localparam int C_OC = 4;   // overcurrent
endpackage

// File: rtl/fs_tick.sv
// Tick prescaler: emits a one-clock pulse every DIV clocks (1 MHz time base).
// Assumes DIV >= 1; with DIV == 1 every clock is a tick.
module fs_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt;
            // Count clocks and wrap at DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n)                   cnt <= '0;
                else if (cnt == CW'(DIV - 1)) cnt <= '0;
                else                          cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/fs_timer.sv
// Loadable down counter in ticks; busy while the count is non-zero.
// Assumes load takes priority over a same-cycle tick.
module fs_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt;

    // Capture on load, otherwise decrement once per tick down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R7
    AST_TIMER_HOLDS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> (cnt == $past(cnt))); // R8
endmodule

// File: rtl/fault_supervisor.sv
// Fault supervisor for a three-phase gate driver. Classifies fault inputs by
// a per-class latch/retry mask, times retries and start-up on a shared tick,
// and derives gate enable, fault pin, start-ready and bootstrap request.
// Assumes all inputs are synchronous to clk; strobes may be one cycle wide.
module fault_supervisor #(
    parameter int                           TICK_DIV      = 4,
    parameter int                           STARTUP_TICKS = 1000,
    parameter int                           BST_TICKS     = 5,
    parameter int                           OFF_W         = 16,
    parameter logic [fs_pkg::NUM_CLASSES-1:0] LATCH_MASK  = 5'b00100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_low,
    input  logic             sleep_n,
    input  logic             temp_ok,
    input  logic             ot_flt,
    input  logic             gv_low,
    input  logic             hs_short,
    input  logic             ls_short,
    input  logic             oc_flt,
    input  logic [OFF_W-1:0] off_time,
    output logic             gate_en,
    output logic             fault_n,
    output logic             start_ready,
    output logic             bst_req
);
    import fs_pkg::*;

    localparam int TW = OFF_W + 2;
    localparam int SW = $clog2(STARTUP_TICKS + 1);
    localparam int BW = $clog2(BST_TICKS + 1);

    logic [NUM_CLASSES-1:0] flt, latch_req, retry_req;
    logic tick, wipe, any_latch;
    logic latched, ot_wait, gv_wait, pu_pend;
    logic off_busy, bst_busy, st_busy;
    logic off_load, bst_load, st_load, gv_rec;
    logic [TW-1:0] off_val;

    assign flt = {oc_flt, ls_short, hs_short, gv_low, ot_flt};

    // Split each fault into a latch request or a retry request by policy.
    generate
        for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_policy
            if (LATCH_MASK[i]) begin : g_latch
                assign latch_req[i] = flt[i];
                assign retry_req[i] = 1'b0;
            end else begin : g_retry
                assign latch_req[i] = 1'b0;
                assign retry_req[i] = flt[i];
            end
        end
    endgenerate

    assign any_latch = |latch_req;
    assign wipe      = supply_low | !sleep_n;

    fs_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    // Latch-off state: set by latching faults, cleared only by a wipe.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) latched <= 1'b0;
        else if (any_latch) latched <= 1'b1;
    end

    // Overtemperature retry: wait until temp_ok is sampled high.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)                      ot_wait <= 1'b0;
        else if (retry_req[C_OT] && !any_latch)  ot_wait <= 1'b1;
        else if (temp_ok)                        ot_wait <= 1'b0;
    end

    // Gate-supply retry: wait while the supply is low, then start charging.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)                      gv_wait <= 1'b0;
        else if (retry_req[C_GV] && !any_latch)  gv_wait <= 1'b1;
        else if (gv_rec)                         gv_wait <= 1'b0;
    end

    // Power-up pending flag so the start-up hold-off also follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pu_pend <= 1'b1;
        else        pu_pend <= 1'b0;
    end

    assign gv_rec   = gv_wait && !gv_low && !wipe;
    assign off_load = wipe || (!any_latch && (retry_req[C_LS] || retry_req[C_OC]));
    assign off_val  = wipe ? '0 :
                      retry_req[C_LS] ? ({2'b00, off_time} + {1'b0, off_time, 1'b0}) :
                                        {2'b00, off_time};
    assign bst_load = wipe || gv_rec;
    assign st_load  = supply_low || pu_pend;

    fs_timer #(.W(TW)) u_off (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(off_load), .load_val(off_val), .busy(off_busy));

    fs_timer #(.W(BW)) u_bst (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(bst_load), .load_val(wipe ? '0 : BW'(BST_TICKS)), .busy(bst_busy));

    fs_timer #(.W(SW)) u_start (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(st_load), .load_val(SW'(STARTUP_TICKS)), .busy(st_busy));

    assign start_ready = !st_load && !st_busy;
    assign fault_n     = !(latched || ot_wait || gv_wait || off_busy);
    assign bst_req     = bst_busy;
    assign gate_en     = start_ready && sleep_n && fault_n && !bst_busy;

    AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flt) && off_time != '0) |=> !gate_en); // R1
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !supply_low && sleep_n) |=> (latched && !fault_n)); // R2
    AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (fault_n && !start_ready)); // R3
    AST_BST_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        gv_rec |=> (bst_req && !gate_en)); // R9
    AST_LATCH_BEATS_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (any_latch && !off_busy && !wipe) |=> !off_busy); // R10
    AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |-> !gate_en); // R11
endmodule

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;
    localparam int DIV = 4;
    localparam int STARTUP = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0, sleep_n = 1'b1, temp_ok = 1'b1;
    logic ot_flt = 1'b0, gv_low = 1'b0, hs_short = 1'b0, ls_short = 1'b0, oc_flt = 1'b0;
    logic [15:0] off_time = 16'd10;
    logic gate_en, fault_n, start_ready, bst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        logic  g, f, r, b;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    fault_supervisor uut (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .sleep_n(sleep_n),
        .temp_ok(temp_ok), .ot_flt(ot_flt), .gv_low(gv_low), .hs_short(hs_short),
        .ls_short(ls_short), .oc_flt(oc_flt), .off_time(off_time),
        .gate_en(gate_en), .fault_n(fault_n), .start_ready(start_ready), .bst_req(bst_req));

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: push one expected item and let the monitor consume it.
    task automatic expect_st(input string req, input logic g, input logic f,
                             input logic r, input logic b);
        exp_t e;
        e.req = req; e.g = g; e.f = f; e.r = r; e.b = b;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        cyc(1);
        sig = 1'b0;
    endtask

    // Monitor: pop expected items and compare against the live outputs.
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            checks++;
            if ({gate_en, fault_n, start_ready, bst_req} !== {e.g, e.f, e.r, e.b}) begin
                errors++;
                $display("FAIL %s: got gate_en/fault_n/ready/bst=%b%b%b%b expected %b%b%b%b",
                         e.req, gate_en, fault_n, start_ready, bst_req, e.g, e.f, e.r, e.b);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        expect_st("R4 reset state", 0, 1, 0, 0);
        cyc(3975);
        expect_st("R4 hold-off still active", 0, 1, 0, 0);
        cyc(40);
        expect_st("R4 hold-off done", 1, 1, 1, 0);

        // R7 / R8: overcurrent retry with off time captured at the fault
        pulse(oc_flt);
        off_time = 16'd1000;
        expect_st("R1 R7 overcurrent disables", 0, 0, 1, 0);
        cyc(31);
        expect_st("R8 off period not stretched yet", 0, 0, 1, 0);
        cyc(16);
        expect_st("R7 R8 overcurrent recovered", 1, 1, 1, 0);
        off_time = 16'd10;

        // R6: low-side short retries after three times the off time
        pulse(ls_short);
        expect_st("R1 R6 low-side short disables", 0, 0, 1, 0);
        cyc(109);
        expect_st("R6 low-side still off", 0, 0, 1, 0);
        cyc(18);
        expect_st("R6 low-side recovered", 1, 1, 1, 0);

        // R2 / R11: high-side short latches until a sleep cycle
        pulse(hs_short);
        expect_st("R2 R6 high-side latches", 0, 0, 1, 0);
        cyc(200);
        expect_st("R2 latch persists", 0, 0, 1, 0);
        sleep_n = 1'b0;
        cyc(3);
        expect_st("R11 sleep forces off", 0, 1, 1, 0);
        sleep_n = 1'b1;
        cyc(1);
        expect_st("R2 sleep cycle clears latch", 1, 1, 1, 0);

        // R5: overtemperature retry waits for temp_ok
        temp_ok = 1'b0;
        pulse(ot_flt);
        expect_st("R5 overtemperature disables", 0, 0, 1, 0);
        cyc(100);
        expect_st("R5 still hot", 0, 0, 1, 0);
        temp_ok = 1'b1;
        cyc(1);
        expect_st("R5 cooled and re-enabled", 1, 1, 1, 0);

        // R9: gate-supply retry goes through a bootstrap charge phase
        gv_low = 1'b1;
        cyc(1);
        expect_st("R9 gate supply low disables", 0, 0, 1, 0);
        gv_low = 1'b0;
        cyc(1);
        expect_st("R9 bootstrap charge requested", 0, 1, 1, 1);
        cyc(8);
        expect_st("R9 bootstrap charge continues", 0, 1, 1, 1);
        cyc(20);
        expect_st("R9 driving resumes", 1, 1, 1, 0);

        // R10: latch and retry in the same cycle
        oc_flt = 1'b1; hs_short = 1'b1;
        cyc(1);
        oc_flt = 1'b0; hs_short = 1'b0;
        expect_st("R10 simultaneous faults disable", 0, 0, 1, 0);
        cyc(60);
        expect_st("R10 latch wins over retry", 0, 0, 1, 0);

        // R3 / R4: supply dip clears the latch and restarts hold-off
        supply_low = 1'b1;
        cyc(3);
        expect_st("R3 supply low clears faults", 0, 1, 0, 0);
        supply_low = 1'b0;
        cyc(3975);
        expect_st("R4 hold-off after supply return", 0, 1, 0, 0);
        cyc(40);
        expect_st("R3 R4 running after supply return", 1, 1, 1, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule